// File: doc/BRIEF.md
# Configurable Parallel I/O Port Group

This block gives a host a 24-line parallel interface organised as three 8-bit ports, A, B and C. A small register interface with a 2-bit address lets the host write a control word that sets the direction of each pin group, write data into per-port output latches, and read back each port. A port set as output drives its latched value. A port set as input returns its pin levels after a two-flop synchroniser. Port C is split into an upper and a lower nibble, and each nibble has its own direction.

For every pin group the block exports a drive-enable output that steers an external tristate line buffer. The buffer direction therefore always follows the programmed mode. After reset every group is an input and every enable is low, so the lines sit at their pulled-up idle level until software writes a control word. Writing the control word clears all output latches. A port that changes direction never drives stale data.

Top module: `pio24`

## Requirements
- R1: While reset is asserted and after it is released, all four drive enables are low and all output latches read zero on the pin outputs, so every group starts as an input.
- R2: A write to address 3 sets the group directions from the data bit: bit 4 for port A, bit 1 for port B, bit 3 for the upper nibble of C and bit 0 for the lower nibble of C. A 1 selects input (enable low) and a 0 selects output (enable high). The new enables are visible in the cycle after the write.
- R3: A write to address 3 sets every output latch of ports A, B and C to zero in the cycle after the write.
- R4: A write to address 0, 1 or 2 loads the data into the latch of port A, B or C, whatever the direction. The latch appears on that port's pin output in the cycle after the write.
- R5: Reading address 0, 1 or 2 for a port or nibble set as output returns the latched value.
- R6: Reading a port or nibble set as input returns its pin level through two register stages. A pin change is not visible after one clock edge and is visible after the second.
- R7: The two nibbles of port C are read independently. Each nibble returns either its latch or its synchronised pins according to its own direction bit.
- R8: Reading address 3 returns zero.
- R9: A write to a data address leaves all drive enables unchanged. The enables change only on a control word write or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 port A, 1 port B, 2 port C, 3 control word |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pb_in | input | 8 | Port B pin levels |
| pc_in | input | 8 | Port C pin levels |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 1 | Port A buffer drive enable |
| pb_oe | output | 1 | Port B buffer drive enable |
| pc_hi_oe | output | 1 | Port C bits 7..4 buffer drive enable |
| pc_lo_oe | output | 1 | Port C bits 3..0 buffer drive enable |

## Verification
The assertions assume that the address and write data are stable around the clock edge on which wr_en is high, and that only one register is written per cycle. The bench keeps to this by changing addr, wr_en and wr_data only on the falling clock edge. It changes the pins the same way and then allows two rising edges before it expects an input read to show the new level.

// File: rtl/pio24_pkg.sv
package pio24_pkg;
    localparam int PORT_W   = 8;
    localparam int HALF_W   = PORT_W / 2;
    localparam int N_PORTS  = 3;
    localparam int ALL_W    = PORT_W * N_PORTS;

    typedef logic [1:0] reg_addr_t;
    localparam reg_addr_t SEL_A   = 2'd0;
    localparam reg_addr_t SEL_B   = 2'd1;
    localparam reg_addr_t SEL_C   = 2'd2;
    localparam reg_addr_t SEL_CTL = 2'd3;

    // control word bit positions, 1 = input
    localparam int CTL_BIT_A  = 4;
    localparam int CTL_BIT_B  = 1;
    localparam int CTL_BIT_CH = 3;
    localparam int CTL_BIT_CL = 0;

    typedef struct packed {
        logic a_inp;
        logic b_inp;
        logic ch_inp;
        logic cl_inp;
    } grp_dir_t;

    localparam grp_dir_t DIR_AT_RESET = '{a_inp: 1'b1, b_inp: 1'b1, ch_inp: 1'b1, cl_inp: 1'b1};
endpackage

// File: rtl/pio24_sync.sv
module pio24_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = raw;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign synced = st_q.stage2;
endmodule

// File: rtl/pio24_latch.sv
module pio24_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)       st_d.val = '0;
        else if (load) st_d.val = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/pio24_ctrl.sv
module pio24_ctrl
    import pio24_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_addr_t        addr,
    input  logic [PORT_W-1:0] wr_data,
    output grp_dir_t         dir,
    output logic             clr_all
);
    typedef struct packed {
        grp_dir_t dir;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    ctl_wr;

    always_comb begin
        ctl_wr = wr_en && (addr == SEL_CTL);
        st_d   = st_q;
        if (ctl_wr) begin
            st_d.dir.a_inp  = wr_data[CTL_BIT_A];
            st_d.dir.b_inp  = wr_data[CTL_BIT_B];
            st_d.dir.ch_inp = wr_data[CTL_BIT_CH];
            st_d.dir.cl_inp = wr_data[CTL_BIT_CL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.dir <= DIR_AT_RESET;
        else        st_q     <= st_d;
    end

    assign dir     = st_q.dir;
    assign clr_all = ctl_wr;
endmodule

// File: rtl/pio24.sv
module pio24
    import pio24_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  addr,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic [7:0]  pa_in,
    input  logic [7:0]  pb_in,
    input  logic [7:0]  pc_in,
    output logic [7:0]  pa_out,
    output logic [7:0]  pb_out,
    output logic [7:0]  pc_out,
    output logic        pa_oe,
    output logic        pb_oe,
    output logic        pc_hi_oe,
    output logic        pc_lo_oe
);
    grp_dir_t          dir;
    logic              clr_all;
    logic [ALL_W-1:0]  pins_sync;
    logic [PORT_W-1:0] lat  [N_PORTS];
    logic [PORT_W-1:0] smp  [N_PORTS];

    pio24_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .dir     (dir),
        .clr_all (clr_all)
    );

    pio24_sync #(.W(ALL_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({pc_in, pb_in, pa_in}),
        .synced (pins_sync)
    );

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        logic sel_wr;
        assign sel_wr = wr_en && (addr == reg_addr_t'(g));
        assign smp[g] = pins_sync[g*PORT_W +: PORT_W];

        pio24_latch #(.W(PORT_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (sel_wr),
            .clr   (clr_all),
            .din   (wr_data),
            .q     (lat[g])
        );
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            SEL_A:   rd_data = dir.a_inp ? smp[0] : lat[0];
            SEL_B:   rd_data = dir.b_inp ? smp[1] : lat[1];
            SEL_C: begin
                rd_data[PORT_W-1:HALF_W] = dir.ch_inp ? smp[2][PORT_W-1:HALF_W] : lat[2][PORT_W-1:HALF_W];
                rd_data[HALF_W-1:0]      = dir.cl_inp ? smp[2][HALF_W-1:0]      : lat[2][HALF_W-1:0];
            end
            default: rd_data = '0;
        endcase
    end

    assign pa_out   = lat[0];
    assign pb_out   = lat[1];
    assign pc_out   = lat[2];
    assign pa_oe    = ~dir.a_inp;
    assign pb_oe    = ~dir.b_inp;
    assign pc_hi_oe = ~dir.ch_inp;
    assign pc_lo_oe = ~dir.cl_inp;
endmodule

// File: rtl/pio24_chk.sv
module pio24_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] pa_out,
    input logic [7:0] pb_out,
    input logic [7:0] pc_out,
    input logic       pa_oe,
    input logic       pb_oe,
    input logic       pc_hi_oe,
    input logic       pc_lo_oe
);
    logic ctl_wr;
    assign ctl_wr = wr_en && (addr == 2'd3);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ({pa_oe, pb_oe, pc_hi_oe, pc_lo_oe} == 4'b0000 &&
                           pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    a_r2_dir_follows_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (pa_oe == !$past(wr_data[4]) && pb_oe == !$past(wr_data[1]) &&
                    pc_hi_oe == !$past(wr_data[3]) && pc_lo_oe == !$past(wr_data[0])));

    a_r3_ctl_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    a_r4_port_a_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> pa_out == $past(wr_data));

    a_r5_read_out_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd1 && pb_oe) |-> rd_data == pb_out);

    a_r8_ctl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        addr == 2'd3 |-> rd_data == 8'h00);

    a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable({pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}));
endmodule

bind pio24 pio24_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pa_out   (pa_out),
    .pb_out   (pb_out),
    .pc_out   (pc_out),
    .pa_oe    (pa_oe),
    .pb_oe    (pb_oe),
    .pc_hi_oe (pc_hi_oe),
    .pc_lo_oe (pc_lo_oe)
);

// File: tb/pio24_bench.sv
module pio24_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pb_out, pc_out;
    logic       pa_oe, pb_oe, pc_hi_oe, pc_lo_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pio24 u_pio24 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
        .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
        .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_hi_oe(pc_hi_oe), .pc_lo_oe(pc_lo_oe)
    );

    typedef struct packed {
        logic       is_wr;
        logic [1:0] ad;
        logic [7:0] dat;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // pins held at A=5A, B=C3, C=96 during the table
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd6},  // R6 A input
        '{1'b0, 2'd1, 8'h00, 8'hC3, 4'd6},  // R6 B input
        '{1'b0, 2'd2, 8'h00, 8'h96, 4'd6},  // R6 C input
        '{1'b0, 2'd3, 8'h00, 8'h00, 4'd8},  // R8 ctl reads zero
        '{1'b1, 2'd3, 8'h00, 8'h00, 4'd2},  // R2 all outputs
        '{1'b0, 2'd0, 8'h00, 8'h00, 4'd3},  // R3 cleared latch
        '{1'b1, 2'd0, 8'h11, 8'h00, 4'd4},  // R4
        '{1'b1, 2'd1, 8'h22, 8'h00, 4'd4},
        '{1'b1, 2'd2, 8'h3C, 8'h00, 4'd4},
        '{1'b0, 2'd0, 8'h00, 8'h11, 4'd5},  // R5
        '{1'b0, 2'd1, 8'h00, 8'h22, 4'd5},
        '{1'b0, 2'd2, 8'h00, 8'h3C, 4'd5},
        '{1'b1, 2'd3, 8'h11, 8'h00, 4'd2},  // R2 A in, C low in
        '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd2},
        '{1'b0, 2'd1, 8'h00, 8'h00, 4'd3},  // R3
        '{1'b0, 2'd2, 8'h00, 8'h06, 4'd7},  // R7 hi latch 0, lo pins 6
        '{1'b1, 2'd2, 8'hA5, 8'h00, 4'd4},
        '{1'b0, 2'd2, 8'h00, 8'hA6, 4'd7},  // R7
        '{1'b1, 2'd3, 8'h08, 8'h00, 4'd2},  // C hi in only
        '{1'b0, 2'd2, 8'h00, 8'h90, 4'd7},  // R7 hi pins 9, lo latch 0
        '{1'b1, 2'd3, 8'h1B, 8'h00, 4'd2},  // all inputs
        '{1'b0, 2'd1, 8'h00, 8'hC3, 4'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
        repeat (3) @(negedge clk);
        // R1 reset state during reset
        check("R1", {28'd0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 32'd0);
        check("R1", {8'd0, pa_out, pb_out, pc_out}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {28'd0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                do_write(VECS[i].ad, VECS[i].dat);
            end else begin
                do_read(VECS[i].ad, v);
                check($sformatf("R%0d vec %0d", VECS[i].req, i), {24'd0, v}, {24'd0, VECS[i].exp});
            end
        end

        // R2 enables after a mixed control word: A out, B in, C hi out, C lo in
        do_write(2'd3, 8'h03);
        check("R2", {28'd0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 32'b1010);
        // R3 control write clears the latches on the pins
        do_write(2'd0, 8'hEE);
        do_write(2'd2, 8'h77);
        check("R4", {16'd0, pa_out, pc_out}, 32'h0000EE77);
        do_write(2'd3, 8'h03);
        check("R3", {8'd0, pa_out, pb_out, pc_out}, 32'd0);
        // R9 data write to an input port loads the latch but keeps the enables
        do_write(2'd1, 8'h5C);
        check("R9", {28'd0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 32'b1010);
        check("R4", {24'd0, pb_out}, 32'h5C);
        do_read(2'd1, v);
        check("R6", {24'd0, v}, 32'hC3);

        // R6 synchroniser latency on port B (input)
        @(negedge clk);
        addr = 2'd1; pb_in = 8'h3E;
        @(negedge clk); #1;
        check("R6 one edge", {24'd0, rd_data}, 32'hC3);
        @(negedge clk); #1;
        check("R6 two edges", {24'd0, rd_data}, 32'h3E);

        // R1 reset in mid-run returns all to input
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid", {28'd0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 32'd0);
        check("R1 mid", {8'd0, pa_out, pb_out, pc_out}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule